// File: doc/BRIEF.md
# Microcoded SIMD Cluster Sequencer

This block is the control engine for one cluster of a bit-serial processing-element array. Every clock it reads one 68-bit microword from an internal microcode store. Four fields of that word act in the same cycle. A 16-bit scalar unit computes operand addresses and branch flags. A next-address unit picks the following microword. A data-path selector places a value on the single 16-bit bus. An array field is issued to the processing elements together with source and destination plane addresses that are taken from scalar registers. Because the array instruction is registered while the scalar unit is already updating the address registers, the address arithmetic for the next array operation overlaps the current one.

Work reaches the block through a shared 16-bit memory with a host port and a controller port. Software places command words in a ring inside that memory and advances a tail pointer. The microprogram polls the ring, dispatches on the command's opcode byte, writes its results into the memory, advances the head pointer and then raises a one-cycle event to the host. The microcode store is written through a load port while reset is held.

Top module: `simd_seq_ctrl`

## Requirements
- R1: Microword bit positions: pe_op [67:60], pe_src_sel [59:57], pe_dst_sel [56:54], seq_mode [53:51], cond_sel [50:49], cond_inv [48], target [47:36], alu_op [35:32], rd [31:29], ra [28:26], rb [25:23], event [22], bus_src [21:20], mem_we [19], mem_areg [18:16], imm [15:0]. The scalar, sequencer, data-path and array fields of one word all take effect in the same cycle.
- R2: While rst_ni is low, pe_op_o, pe_src_addr_o, pe_dst_addr_o and host_event_o are zero, and execution starts at microcode address 0 when reset is released.
- R3: One clock after a microword is fetched, pe_op_o carries its pe_op field, and pe_src_addr_o and pe_dst_addr_o carry the selected scalar registers as they were before that word's own scalar write. pe_op 0 is the no-operation code.
- R4: alu_op codes: 0 none, 1 pass bus, 2 ra+bus, 3 ra-bus, 4 and, 5 or, 6 xor, 7 ra+1, 8 ra-1. The result goes to register rd. Every code other than 0 also updates three flags: zero, sign (bit 15) and carry/borrow.
- R5: seq_mode codes: 0 continue, 1 jump to target, 2 conditional jump. cond_sel picks the flag: 0 zero, 1 sign, 2 carry, 3 always. cond_inv inverts the chosen condition. A branch tests the flags left by the most recent scalar operation.
- R6: seq_mode 3 jumps to target and pushes the address of the next word. seq_mode 4 pops that address. The stack depth is a parameter.
- R7: seq_mode 5 jumps to target plus bits [7:0] of the bus value, so a command word read from memory selects its microroutine by its low byte.
- R8: bus_src codes: 0 register rb, 1 imm, 2 shared memory word at the address held in register mem_areg, 3 zero.
- R9: With mem_we set, the bus value is written to the shared-memory word addressed by register mem_areg. The host port writes on host_we_i and returns the read word one clock after it presents the address.
- R10: host_event_o is high for exactly the cycle that follows a microword with the event bit set.
- R11: Microcode load writes take effect only while rst_ni is low. Writes made while the block runs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| uc_we_i | input | 1 | Microcode load strobe |
| uc_addr_i | input | 8 | Microcode load address |
| uc_wdata_i | input | 68 | Microword to load |
| host_we_i | input | 1 | Host write strobe to shared memory |
| host_addr_i | input | 11 | Host shared-memory address |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Host read data, one cycle latency |
| pe_op_o | output | 8 | Array operation broadcast |
| pe_src_addr_o | output | 16 | Array source plane address |
| pe_dst_addr_o | output | 16 | Array destination plane address |
| host_event_o | output | 1 | Command completion pulse |

## Verification
A corrupted scalar register or flag shows up as a wrong plane address on the array outputs in the very next issue cycle. It can also show up as a wrong branch, which appears as a different count of array operations or a wrong result word once the command completes. A wrong program counter or stack pointer diverts the microroutine. The wrong result word, a head pointer that does not advance, or a missing or doubled completion pulse then becomes visible within a few tens of cycles. Commands are therefore checked through the full sequence of array issues, the result words and head pointer read back through the host port, and a count of events.

// File: rtl/simd_seq_pkg.sv
package simd_seq_pkg;
  localparam int UW_W   = 68;
  localparam int DATA_W = 16;
  localparam int REG_N  = 8;
  localparam int REG_AW = $clog2(REG_N);
  localparam int TGT_W  = 12;
  localparam int OP_W   = 8;

  typedef enum logic [2:0] {
    SEQ_CONT = 3'd0, SEQ_JUMP = 3'd1, SEQ_CJMP = 3'd2,
    SEQ_CALL = 3'd3, SEQ_RET  = 3'd4, SEQ_DISP = 3'd5
  } seq_mode_e;

  typedef enum logic [3:0] {
    ALU_NOP = 4'd0, ALU_PASS = 4'd1, ALU_ADD = 4'd2, ALU_SUB = 4'd3,
    ALU_AND = 4'd4, ALU_OR   = 4'd5, ALU_XOR = 4'd6, ALU_INC = 4'd7,
    ALU_DEC = 4'd8
  } alu_op_e;

  typedef enum logic [1:0] {
    BUS_REG = 2'd0, BUS_IMM = 2'd1, BUS_MEM = 2'd2, BUS_ZERO = 2'd3
  } bus_src_e;

  typedef struct packed {
    logic [OP_W-1:0]   pe_op;
    logic [REG_AW-1:0] pe_src;
    logic [REG_AW-1:0] pe_dst;
    seq_mode_e         seq_mode;
    logic [1:0]        cond_sel;
    logic              cond_inv;
    logic [TGT_W-1:0]  target;
    alu_op_e           alu_op;
    logic [REG_AW-1:0] rd;
    logic [REG_AW-1:0] ra;
    logic [REG_AW-1:0] rb;
    logic              host_event;
    bus_src_e          bus_src;
    logic              mem_we;
    logic [REG_AW-1:0] mem_areg;
    logic [DATA_W-1:0] imm;
  } uword_t;
endpackage

// File: rtl/simd_uc_store.sv
module simd_uc_store import simd_seq_pkg::*; #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [UW_W-1:0] wdata_i,
  input  logic [AW-1:0]   raddr_i,
  output logic [UW_W-1:0] rdata_o
);
  logic [UW_W-1:0] mem_q [DEPTH];

  // loading is only legal while the sequencer is held in reset
  always_ff @(posedge clk_i) begin
    if (we_i && !rst_ni) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/simd_scalar_unit.sv
module simd_scalar_unit import simd_seq_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  alu_op_e           alu_op_i,
  input  logic [REG_AW-1:0] rd_i,
  input  logic [REG_AW-1:0] ra_i,
  input  logic [REG_AW-1:0] rb_i,
  input  logic [REG_AW-1:0] src_sel_i,
  input  logic [REG_AW-1:0] dst_sel_i,
  input  logic [REG_AW-1:0] areg_sel_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] rb_val_o,
  output logic [DATA_W-1:0] areg_val_o,
  output logic [DATA_W-1:0] src_val_o,
  output logic [DATA_W-1:0] dst_val_o,
  output logic              flag_z_o,
  output logic              flag_n_o,
  output logic              flag_c_o
);
  logic [DATA_W-1:0] regs_q [REG_N];
  logic [DATA_W:0]   res;
  logic [DATA_W-1:0] a;

  assign a          = regs_q[ra_i];
  assign rb_val_o   = regs_q[rb_i];
  assign areg_val_o = regs_q[areg_sel_i];
  assign src_val_o  = regs_q[src_sel_i];
  assign dst_val_o  = regs_q[dst_sel_i];

  always_comb begin
    unique case (alu_op_i)
      ALU_PASS: res = {1'b0, bus_i};
      ALU_ADD:  res = {1'b0, a} + {1'b0, bus_i};
      ALU_SUB:  res = {1'b0, a} - {1'b0, bus_i};
      ALU_AND:  res = {1'b0, a & bus_i};
      ALU_OR:   res = {1'b0, a | bus_i};
      ALU_XOR:  res = {1'b0, a ^ bus_i};
      ALU_INC:  res = {1'b0, a} + 17'd1;
      ALU_DEC:  res = {1'b0, a} - 17'd1;
      default:  res = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < REG_N; i++) regs_q[i] <= '0;
      flag_z_o <= 1'b0;
      flag_n_o <= 1'b0;
      flag_c_o <= 1'b0;
    end else if (alu_op_i != ALU_NOP) begin
      regs_q[rd_i] <= res[DATA_W-1:0];
      flag_z_o     <= (res[DATA_W-1:0] == '0);
      flag_n_o     <= res[DATA_W-1];
      flag_c_o     <= res[DATA_W];
    end
  end

  assert_zero_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_op_i != ALU_NOP) |=> (flag_z_o == (regs_q[$past(rd_i)] == '0)));
  assert_sign_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_op_i != ALU_NOP) |=> (flag_n_o == regs_q[$past(rd_i)][DATA_W-1]));
endmodule

// File: rtl/simd_next_addr.sv
module simd_next_addr import simd_seq_pkg::*; #(
  parameter int PC_W  = 8,
  parameter int STK_D = 4,
  localparam int SAW = $clog2(STK_D),
  localparam int SPW = $clog2(STK_D + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  seq_mode_e        mode_i,
  input  logic [1:0]       cond_sel_i,
  input  logic             cond_inv_i,
  input  logic [TGT_W-1:0] target_i,
  input  logic [7:0]       disp_i,
  input  logic             flag_z_i,
  input  logic             flag_n_i,
  input  logic             flag_c_i,
  output logic [PC_W-1:0]  pc_o
);
  logic [PC_W-1:0] pc_q, pc_inc, pc_next, tgt, ret_addr;
  logic [PC_W-1:0] stk_q [STK_D];
  logic [SPW-1:0]  sp_q;
  logic            cond, taken;
  logic            unused_tgt;

  assign tgt        = target_i[PC_W-1:0];
  assign unused_tgt = ^target_i[TGT_W-1:PC_W];
  assign pc_inc     = pc_q + 1'b1;
  assign ret_addr   = (sp_q != '0) ? stk_q[SAW'(sp_q - 1'b1)] : '0;

  always_comb begin
    unique case (cond_sel_i)
      2'd0:    cond = flag_z_i;
      2'd1:    cond = flag_n_i;
      2'd2:    cond = flag_c_i;
      default: cond = 1'b1;
    endcase
    taken = cond ^ cond_inv_i;
    unique case (mode_i)
      SEQ_JUMP: pc_next = tgt;
      SEQ_CJMP: pc_next = taken ? tgt : pc_inc;
      SEQ_CALL: pc_next = tgt;
      SEQ_RET:  pc_next = ret_addr;
      SEQ_DISP: pc_next = tgt + PC_W'(disp_i);
      default:  pc_next = pc_inc;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      sp_q <= '0;
    end else begin
      pc_q <= pc_next;
      if (mode_i == SEQ_CALL && sp_q < SPW'(STK_D)) begin
        stk_q[SAW'(sp_q)] <= pc_inc;
        sp_q <= sp_q + 1'b1;
      end else if (mode_i == SEQ_RET && sp_q != '0) begin
        sp_q <= sp_q - 1'b1;
      end
    end
  end

  assign pc_o = pc_q;

  assert_seq_cont_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SEQ_CONT) |=> (pc_q == $past(pc_q) + 1'b1));
  assert_stack_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SEQ_CALL) |-> (sp_q < SPW'(STK_D)));
  assert_stack_no_underflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SEQ_RET) |-> (sp_q != '0));
endmodule

// File: rtl/simd_shared_mem.sv
module simd_shared_mem import simd_seq_pkg::*; #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              host_we_i,
  input  logic [AW-1:0]     host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  input  logic              ctl_we_i,
  input  logic [AW-1:0]     ctl_addr_i,
  input  logic [DATA_W-1:0] ctl_wdata_i,
  output logic [DATA_W-1:0] ctl_rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  // controller port is written last and wins a same-address collision
  always_ff @(posedge clk_i) begin
    if (host_we_i) mem_q[host_addr_i] <= host_wdata_i;
    if (ctl_we_i)  mem_q[ctl_addr_i]  <= ctl_wdata_i;
    host_rdata_o <= mem_q[host_addr_i];
  end

  assign ctl_rdata_o = mem_q[ctl_addr_i];
endmodule

// File: rtl/simd_seq_ctrl.sv
module simd_seq_ctrl import simd_seq_pkg::*; #(
  parameter int UC_DEPTH  = 256,
  parameter int STK_D     = 4,
  parameter int SHM_DEPTH = 2048,
  localparam int UC_AW  = $clog2(UC_DEPTH),
  localparam int SHM_AW = $clog2(SHM_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              uc_we_i,
  input  logic [UC_AW-1:0]  uc_addr_i,
  input  logic [UW_W-1:0]   uc_wdata_i,
  input  logic              host_we_i,
  input  logic [SHM_AW-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic [OP_W-1:0]   pe_op_o,
  output logic [DATA_W-1:0] pe_src_addr_o,
  output logic [DATA_W-1:0] pe_dst_addr_o,
  output logic              host_event_o
);
  logic [UC_AW-1:0]  pc;
  logic [UW_W-1:0]   uc_raw;
  uword_t            uw;
  logic [DATA_W-1:0] bus, rb_val, areg_val, src_val, dst_val, shm_rdata;
  logic              fz, fn, fc;
  logic              unused_addr_hi;

  assign uw             = uword_t'(uc_raw);
  assign unused_addr_hi = ^areg_val[DATA_W-1:SHM_AW];

  simd_uc_store #(.DEPTH(UC_DEPTH)) u_store (
    .clk_i, .rst_ni, .we_i(uc_we_i), .waddr_i(uc_addr_i), .wdata_i(uc_wdata_i),
    .raddr_i(pc), .rdata_o(uc_raw)
  );

  always_comb begin
    unique case (uw.bus_src)
      BUS_REG: bus = rb_val;
      BUS_IMM: bus = uw.imm;
      BUS_MEM: bus = shm_rdata;
      default: bus = '0;
    endcase
  end

  simd_scalar_unit u_scalar (
    .clk_i, .rst_ni, .alu_op_i(uw.alu_op), .rd_i(uw.rd), .ra_i(uw.ra), .rb_i(uw.rb),
    .src_sel_i(uw.pe_src), .dst_sel_i(uw.pe_dst), .areg_sel_i(uw.mem_areg), .bus_i(bus),
    .rb_val_o(rb_val), .areg_val_o(areg_val), .src_val_o(src_val), .dst_val_o(dst_val),
    .flag_z_o(fz), .flag_n_o(fn), .flag_c_o(fc)
  );

  simd_next_addr #(.PC_W(UC_AW), .STK_D(STK_D)) u_next (
    .clk_i, .rst_ni, .mode_i(uw.seq_mode), .cond_sel_i(uw.cond_sel),
    .cond_inv_i(uw.cond_inv), .target_i(uw.target), .disp_i(bus[7:0]),
    .flag_z_i(fz), .flag_n_i(fn), .flag_c_i(fc), .pc_o(pc)
  );

  simd_shared_mem #(.DEPTH(SHM_DEPTH)) u_shm (
    .clk_i, .host_we_i, .host_addr_i, .host_wdata_i, .host_rdata_o,
    .ctl_we_i(uw.mem_we), .ctl_addr_i(areg_val[SHM_AW-1:0]), .ctl_wdata_i(bus),
    .ctl_rdata_o(shm_rdata)
  );

  // array issue stage: scalar unit already works on the next addresses
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pe_op_o       <= '0;
      pe_src_addr_o <= '0;
      pe_dst_addr_o <= '0;
      host_event_o  <= 1'b0;
    end else begin
      pe_op_o       <= uw.pe_op;
      pe_src_addr_o <= src_val;
      pe_dst_addr_o <= dst_val;
      host_event_o  <= uw.host_event;
    end
  end

  assert_pe_issue_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pe_op_o == $past(uw.pe_op)));
  assert_event_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uw.host_event |=> host_event_o);
  assert_event_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uw.host_event |=> !host_event_o);
endmodule

// File: tb/simd_seq_ctrl_tb.sv
module simd_seq_ctrl_tb;
  localparam int CONT = 0, JUMP = 1, CJMP = 2, CALL = 3, RET = 4, DISP = 5;
  localparam int NOP = 0, PASS = 1, ADD = 2, SUB = 3, AND = 4, INC = 7, DEC = 8;
  localparam int REG = 0, IMM = 1, MEM = 2;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        uc_we = 1'b0;
  logic [7:0]  uc_addr = '0;
  logic [67:0] uc_wdata = '0;
  logic        h_we = 1'b0;
  logic [10:0] h_addr = '0;
  logic [15:0] h_wdata = '0;
  logic [15:0] h_rdata;
  logic [7:0]  pe_op;
  logic [15:0] pe_src, pe_dst;
  logic        ev;

  int n_chk = 0, n_fail = 0, ev_cnt = 0, n_tr = 0, tail = 0;
  logic [7:0]  tr_op  [32];
  logic [15:0] tr_src [32];
  logic [15:0] tr_dst [32];
  bit done = 1'b0;

  always #4 clk = ~clk;

  simd_seq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .uc_we_i(uc_we), .uc_addr_i(uc_addr),
    .uc_wdata_i(uc_wdata), .host_we_i(h_we), .host_addr_i(h_addr),
    .host_wdata_i(h_wdata), .host_rdata_o(h_rdata), .pe_op_o(pe_op),
    .pe_src_addr_o(pe_src), .pe_dst_addr_o(pe_dst), .host_event_o(ev)
  );

  always @(negedge clk) begin
    if (rst_n && pe_op != 8'h00 && n_tr < 32) begin
      tr_op[n_tr] = pe_op; tr_src[n_tr] = pe_src; tr_dst[n_tr] = pe_dst;
      n_tr = n_tr + 1;
    end
    if (rst_n && ev) ev_cnt = ev_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [67:0] mk(int pe, int ps, int pd, int sm, int cs, int ci,
      int tg, int ao, int rd, int ra, int rb, int e, int bs, int we, int ar, int im);
    return {pe[7:0], ps[2:0], pd[2:0], sm[2:0], cs[1:0], ci[0], tg[11:0], ao[3:0],
            rd[2:0], ra[2:0], rb[2:0], e[0], bs[1:0], we[0], ar[2:0], im[15:0]};
  endfunction

  task automatic uc(input int a, input logic [67:0] w);
    @(negedge clk); uc_we = 1'b1; uc_addr = a[7:0]; uc_wdata = w;
    @(negedge clk); uc_we = 1'b0;
  endtask

  task automatic hw(input int a, input int d);
    @(negedge clk); h_we = 1'b1; h_addr = a[10:0]; h_wdata = d[15:0];
    @(negedge clk); h_we = 1'b0;
  endtask

  task automatic hr(input int a, output logic [15:0] d);
    @(negedge clk); h_addr = a[10:0];
    @(negedge clk); d = h_rdata;
  endtask

  task automatic wait_evt(input string req);
    int c;
    for (c = 0; c < 600 && !ev; c++) @(negedge clk);
    chk({req, " event seen"}, 32'(ev), 32'd1);
    @(negedge clk);
    chk("R10 event one cycle wide", 32'(ev), 32'd0);
  endtask

  task automatic post(input int cmd);
    hw(16 + tail, cmd);
    tail = (tail + 1) % 16;
    hw(1, tail);
  endtask

  task automatic load_program();
    uc(0,  mk(0,0,0,CONT,0,0,0, PASS,1,0,0,0,MEM,0,0,0));
    uc(1,  mk(0,0,0,CONT,0,0,0, PASS,2,0,0,0,IMM,0,0,1));
    uc(2,  mk(0,0,0,CONT,0,0,0, PASS,3,0,0,0,MEM,0,2,0));
    uc(3,  mk(0,0,0,CONT,0,0,0, SUB,4,1,3,0,REG,0,0,0));
    uc(4,  mk(0,0,0,CJMP,0,0,0, NOP,0,0,0,0,REG,0,0,0));
    uc(5,  mk(0,0,0,CONT,0,0,0, ADD,5,1,0,0,IMM,0,0,16));
    uc(6,  mk(0,0,0,DISP,0,0,16, PASS,6,0,0,0,MEM,0,5,0));
    uc(16, mk(0,0,0,JUMP,0,0,32, NOP,0,0,0,0,REG,0,0,0));
    uc(17, mk(0,0,0,JUMP,0,0,40, NOP,0,0,0,0,REG,0,0,0));
    uc(18, mk(0,0,0,JUMP,0,0,44, NOP,0,0,0,0,REG,0,0,0));
    uc(19, mk(0,0,0,JUMP,0,0,52, NOP,0,0,0,0,REG,0,0,0));
    uc(32, mk(0,0,0,CONT,0,0,0, PASS,7,0,0,0,IMM,0,0,16'h0100));
    uc(33, mk(0,0,0,CONT,0,0,0, PASS,4,0,0,0,IMM,0,0,3));
    uc(34, mk(8'h21,7,7,CONT,0,0,0, INC,7,7,0,0,REG,0,0,0));
    uc(35, mk(0,0,0,CONT,0,0,0, DEC,4,4,0,0,REG,0,0,0));
    uc(36, mk(0,0,0,CJMP,0,1,34, NOP,0,0,0,0,REG,0,0,0));
    uc(37, mk(0,0,0,CONT,0,0,0, PASS,2,0,0,0,IMM,0,0,16'h0040));
    uc(38, mk(0,0,0,JUMP,0,0,48, NOP,0,0,7,0,REG,1,2,0));
    uc(40, mk(0,0,0,CALL,0,0,56, NOP,0,0,0,0,REG,0,0,0));
    uc(41, mk(0,0,0,JUMP,0,0,48, NOP,0,0,0,0,REG,0,0,0));
    uc(44, mk(0,0,0,CONT,0,0,0, PASS,2,0,0,0,IMM,0,0,16'h0042));
    uc(45, mk(0,0,0,CONT,0,0,0, ADD,3,6,0,0,IMM,0,0,5));
    uc(46, mk(0,0,0,JUMP,0,0,48, NOP,0,0,3,0,REG,1,2,0));
    uc(48, mk(0,0,0,CONT,0,0,0, INC,1,1,0,0,REG,0,0,0));
    uc(49, mk(0,0,0,CONT,0,0,0, AND,1,1,0,0,IMM,0,0,15));
    uc(50, mk(0,0,0,JUMP,0,0,0, NOP,0,0,1,1,REG,1,0,0));
    uc(52, mk(0,0,0,CONT,0,0,0, SUB,3,0,0,0,IMM,0,0,1));
    uc(53, mk(0,0,0,CJMP,1,0,60, NOP,0,0,0,0,REG,0,0,0));
    uc(54, mk(0,0,0,CONT,0,0,0, PASS,2,0,0,0,IMM,0,0,16'h0043));
    uc(55, mk(0,0,0,JUMP,0,0,48, NOP,0,0,0,0,IMM,1,2,16'h0055));
    uc(56, mk(8'h33,0,0,CONT,0,0,0, PASS,2,0,0,0,IMM,0,0,16'h0041));
    uc(57, mk(0,0,0,RET,0,0,0, NOP,0,0,0,0,IMM,1,2,16'hBEEF));
    uc(60, mk(0,0,0,CONT,0,0,0, PASS,2,0,0,0,IMM,0,0,16'h0043));
    uc(61, mk(0,0,0,JUMP,0,0,48, NOP,0,0,0,0,IMM,1,2,16'h00AA));
  endtask

  task automatic t_reset();
    hw(0, 0); hw(1, 0);
    @(negedge clk);
    chk("R2 pe_op in reset", 32'(pe_op), 32'd0);
    chk("R2 src in reset", 32'(pe_src), 32'd0);
    chk("R2 dst in reset", 32'(pe_dst), 32'd0);
    chk("R2 event in reset", 32'(ev), 32'd0);
    rst_n = 1'b1;
    repeat (60) @(negedge clk);
    chk("R5 idle loop issues no array op", 32'(n_tr), 32'd0);
    chk("R5 idle loop raises no event", 32'(ev_cnt), 32'd0);
  endtask

  task automatic t_plane_loop();
    logic [15:0] d;
    int e0 = ev_cnt;
    n_tr = 0;
    post(16'h0000);
    wait_evt("R7 op0");
    chk("R3 plane op count", 32'(n_tr), 32'd3);
    for (int i = 0; i < 3; i++) begin
      chk("R3 pe op code", 32'(tr_op[i]), 32'h21);
      chk("R1 src address overlaps increment", 32'(tr_src[i]), 32'h100 + 32'(i));
      chk("R3 dst address", 32'(tr_dst[i]), 32'h100 + 32'(i));
    end
    hr(16'h40, d);
    chk("R9 op0 result word", 32'(d), 32'h0103);
    hr(0, d);
    chk("R9 head advanced", 32'(d), 32'd1);
    chk("R10 one event per command", 32'(ev_cnt - e0), 32'd1);
  endtask

  task automatic t_call();
    logic [15:0] d;
    n_tr = 0;
    post(16'h0001);
    wait_evt("R6 op1");
    chk("R6 subroutine issued once", 32'(n_tr), 32'd1);
    chk("R6 subroutine pe op", 32'(tr_op[0]), 32'h33);
    chk("R8 src from register 0", 32'(tr_src[0]), 32'd0);
    hr(16'h41, d);
    chk("R6 return resumed caller", 32'(d), 32'hBEEF);
  endtask

  task automatic t_arith();
    logic [15:0] d;
    post(16'h1202);
    wait_evt("R7 op2");
    hr(16'h42, d);
    chk("R4 add on command word", 32'(d), 32'h1207);
    hr(0, d);
    chk("R9 head after three commands", 32'(d), 32'd3);
  endtask

  task automatic t_branch();
    logic [15:0] d;
    post(16'h0003);
    wait_evt("R5 op3");
    hr(16'h43, d);
    chk("R5 sign-flag branch taken", 32'(d), 32'h00AA);
  endtask

  task automatic t_two_queued();
    logic [15:0] d;
    int e0 = ev_cnt;
    hw(16 + tail, 16'h0502);
    hw(16 + (tail + 1) % 16, 16'h0001);
    tail = (tail + 2) % 16;
    hw(1, tail);
    wait_evt("R7 first queued");
    wait_evt("R7 second queued");
    hr(16'h42, d);
    chk("R8 memory bus dispatch result", 32'(d), 32'h0507);
    hr(0, d);
    chk("R9 head after two queued", 32'(d), 32'd6);
    chk("R10 two events", 32'(ev_cnt - e0), 32'd2);
  endtask

  task automatic t_load_locked();
    int n0;
    uc(0, mk(8'h77,0,0,JUMP,0,0,0, NOP,0,0,0,0,REG,0,0,0));
    n0 = n_tr;
    repeat (40) @(negedge clk);
    chk("R11 load ignored while running", 32'(n_tr - n0), 32'd0);
    hw(16'h44, 16'h5A5A);
    hr(16'h44, h_rdata_dummy);
    chk("R9 host write then read", 32'(h_rdata_dummy), 32'h5A5A);
  endtask

  logic [15:0] h_rdata_dummy;

  initial begin
    load_program();
    t_reset();
    t_plane_loop();
    t_call();
    t_arith();
    t_branch();
    t_two_queued();
    t_load_locked();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule